// File: doc/BRIEF.md
# Palette and frame fetch sequencer

This block sits between the memory-side stream feeding a display controller and the raster timing logic. Once enabled, it pulls 16-bit words from a valid/ready stream and sorts them by phase. It first loads a colour lookup table, then the pixel data, or only one of the two, as chosen by a load-mode field. Palette words are written in arrival order into an internal lookup RAM. The first palette word also carries a pixel-depth code, and that code sets how many entries follow. Frame words go into a shallow FIFO, and the timing side drains that FIFO one pixel per request.

Clearing the enable bit does not cut the fetch short. The block completes the pass it is in, raises a sticky frame-done flag when the last word of the frame has been accepted, and then goes idle. Seven sticky status flags report progress and faults, and each flag has its own interrupt enable. Each flag clears under its own rule: by a write of one, on disable, or only when the block is restarted.

The stream input follows the usual valid/ready rules. A word transfers on a rising edge where both `s_valid` and `s_ready` are high. `s_ready` depends only on the internal phase and the FIFO fill level, never on `s_valid`. `s_ready` is low while the block is idle, while it holds after a palette-only load, and while the FIFO is full. An upstream source may therefore hold `s_valid` high with stable data for as long as it needs.

Top module: `pal_frame_fetch`

## Requirements
- R1: A fetch starts on the first clock edge where the block is idle and `ctl_enable` is high. Load mode 0 fetches palette then frame, mode 1 fetches palette only, and modes 2 and 3 fetch frame only. In modes 2 and 3 every word goes to the FIFO and none is written to the palette RAM.
- R2: Bits 15:12 of the first palette word are the depth code, and they appear on `pal_depth`. Code 0x3 selects a 256-entry palette. Every other code selects a 16-entry palette. The length is fixed by the first word and is not changed by later words.
- R3: Palette word n writes bits 11:0 (red 11:8, green 7:4, blue 3:0) into entry n. `pal_rd_color` shows entry `pal_rd_idx` one cycle after the index is applied.
- R4: In palette-only mode, the clock edge that accepts the last palette word also sets status bit 1 (palette loaded) and drops `s_ready`. `s_ready` then stays low until the block is disabled.
- R5: While the block is enabled, frames repeat back to back. After `ctl_enable` falls, the block keeps fetching until the last word of the current frame (LINE_WORDS×FRAME_LINES words) is accepted. At that edge it sets status bit 0 (done) and goes idle with `s_ready` low. A palette-only hold ends the same way on the first edge where `ctl_enable` is low.
- R6: Status bit 0 cannot be cleared by a status write. It clears only when a new fetch starts.
- R7: Status bit 2 (underflow) and status bit 3 (sync lost) ignore status writes. Both clear on the edge after `ctl_enable` falls. Bit 3 is set by `evt_sync_lost`.
- R8: In load mode 1, status bit 1 is cleared by writing a one to it. In the other modes, such a write is ignored and bit 1 clears when `ctl_enable` falls.
- R9: Status bits 4 (vsync), 5 (line) and 6 (AC-bias count) are set by `evt_vsync`, `evt_line` and `evt_acb` and cleared by writing a one. If a set and a clear hit the same bit on the same edge, the set wins.
- R10: If `pix_req` and `pix_active` are both high while the FIFO is empty, `pix_data` is zero in the next cycle and status bit 2 is set. A request with `pix_active` low pops nothing and flags nothing.
- R11: Frame words leave in arrival order, on `pix_data`, one cycle after the request that pops them. `s_ready` is low while the FIFO holds FIFO_DEPTH words.
- R12: `irq` is high exactly when some status bit and its matching `irq_en` bit are both high.
- R13: After reset, all status bits are zero, and `irq`, `s_ready`, `pix_data` and `pal_depth` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_enable | input | 1 | Enable bit from the control register |
| ctl_load_mode | input | 2 | Load-mode field: 0 palette+frame, 1 palette, 2/3 frame |
| irq_en | input | 7 | Per-status-bit interrupt enables |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 7 | Status write data, one means clear where allowed |
| evt_vsync | input | 1 | Vertical sync event pulse |
| evt_line | input | 1 | Line event pulse |
| evt_acb | input | 1 | AC-bias count event pulse |
| evt_sync_lost | input | 1 | Sync-lost event pulse from the timing side |
| s_valid | input | 1 | Stream word valid |
| s_data | input | 16 | Stream word |
| s_ready | output | 1 | Stream ready |
| pix_req | input | 1 | Pixel request from the timing side |
| pix_active | input | 1 | Timing side is in the active region |
| pix_data | output | 16 | Pixel word, one cycle after a request |
| pal_rd_idx | input | 8 | Palette read index |
| pal_rd_color | output | 12 | Palette colour at the index, one cycle later |
| pal_depth | output | 4 | Depth code from the last palette load |
| status | output | 7 | Sticky status flags |
| irq | output | 1 | Interrupt request |

## Verification
`s_ready` is combinational from registered phase and fill state. It is already valid at the falling edge before a transfer, so the bench drives and samples on falling edges and counts one rising edge per step. Status flags, `pix_data` and `pal_rd_color` each change on the single rising edge that follows their cause, so every check of them is made at the next falling edge. The same edge that accepts the final palette or frame word sets the flag and drops `s_ready`, so the bench checks both at the falling edge straight after the last `send`. `irq` follows status without a register and is checked in the same half-cycle as the status it reflects.

// File: rtl/pff_pkg.sv
package pff_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PAL   = 2'd1,
    SQ_HOLD  = 2'd2,
    SQ_FRAME = 2'd3
  } seq_state_t;

  localparam int STAT_W = 7;
  localparam int B_DONE = 0;
  localparam int B_PAL  = 1;
  localparam int B_UF   = 2;
  localparam int B_SL   = 3;
  localparam int B_VS   = 4;
  localparam int B_LINE = 5;
  localparam int B_ACB  = 6;

  localparam logic [1:0] LM_BOTH  = 2'd0;
  localparam logic [1:0] LM_PAL   = 2'd1;

  localparam logic [3:0] CODE_INDEXED8 = 4'h3;
  localparam int WORD_W  = 16;
  localparam int COLOR_W = 12;
endpackage

// File: rtl/pff_palette_ram.sv
module pff_palette_ram #(
  parameter int ENTRIES = 256,
  parameter int WIDTH   = 12,
  localparam int AW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pff_pixel_fifo.sv
module pff_pixel_fifo #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  assert_no_underflow_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  assert_count_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
endmodule

// File: rtl/pff_status_regs.sv
module pff_status_regs #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] flags
);
  for (genvar k = 0; k < W; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags[k] <= 1'b0;
      else if (set_vec[k]) flags[k] <= 1'b1;
      else if (clr_vec[k]) flags[k] <= 1'b0;
    end
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/pal_frame_fetch.sv
module pal_frame_fetch
  import pff_pkg::*;
#(
  parameter int LINE_WORDS  = 4,
  parameter int FRAME_LINES = 3,
  parameter int FIFO_DEPTH  = 4,
  parameter int PAL_BIG     = 256,
  parameter int PAL_SMALL   = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        ctl_enable,
  input  logic [1:0]                  ctl_load_mode,
  input  logic [6:0]                  irq_en,
  input  logic                        stat_wr,
  input  logic [6:0]                  stat_wdata,
  input  logic                        evt_vsync,
  input  logic                        evt_line,
  input  logic                        evt_acb,
  input  logic                        evt_sync_lost,
  input  logic                        s_valid,
  input  logic [15:0]                 s_data,
  output logic                        s_ready,
  input  logic                        pix_req,
  input  logic                        pix_active,
  output logic [15:0]                 pix_data,
  input  logic [$clog2(PAL_BIG)-1:0]  pal_rd_idx,
  output logic [11:0]                 pal_rd_color,
  output logic [3:0]                  pal_depth,
  output logic [6:0]                  status,
  output logic                        irq
);
  localparam int PAL_AW = $clog2(PAL_BIG);
  localparam int COL_W  = (LINE_WORDS  > 1) ? $clog2(LINE_WORDS)  : 1;
  localparam int ROW_W  = (FRAME_LINES > 1) ? $clog2(FRAME_LINES) : 1;

  seq_state_t        state;
  logic [1:0]        run_mode;
  logic [PAL_AW-1:0] pal_idx, pal_last, pal_last_eff;
  logic [COL_W-1:0]  col;
  logic [ROW_W-1:0]  row;
  logic              en_q;

  logic start, en_fall, hs, pal_hs, frame_hs, pal_end, frame_end, done_set;
  logic fifo_full, fifo_empty, fifo_pop, uf_evt;
  logic [WORD_W-1:0] fifo_dout;
  logic [STAT_W-1:0] set_vec, clr_vec;
  logic [3:0] first_code;

  // ---------------- handshake and phase decode ----------------
  assign start      = (state == SQ_IDLE) && ctl_enable;
  assign en_fall    = en_q && !ctl_enable;
  assign s_ready    = (state == SQ_PAL) || ((state == SQ_FRAME) && !fifo_full);
  assign hs         = s_valid && s_ready;
  assign pal_hs     = hs && (state == SQ_PAL);
  assign frame_hs   = hs && (state == SQ_FRAME);
  assign first_code = s_data[15:12];

  always_comb begin
    if (pal_idx == '0)
      pal_last_eff = (first_code == CODE_INDEXED8) ? PAL_AW'(PAL_BIG - 1)
                                                   : PAL_AW'(PAL_SMALL - 1);
    else
      pal_last_eff = pal_last;
  end

  assign pal_end   = pal_hs && (pal_idx != '0) && (pal_idx == pal_last_eff);
  assign frame_end = frame_hs && (col == COL_W'(LINE_WORDS - 1))
                              && (row == ROW_W'(FRAME_LINES - 1));
  assign done_set  = (frame_end && !ctl_enable) ||
                     ((state == SQ_HOLD) && !ctl_enable);

  // ---------------- sequencer ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      run_mode  <= LM_BOTH;
      pal_idx   <= '0;
      pal_last  <= '0;
      col       <= '0;
      row       <= '0;
      en_q      <= 1'b0;
      pal_depth <= '0;
    end else begin
      en_q <= ctl_enable;
      unique case (state)
        SQ_IDLE: begin
          if (start) begin
            run_mode <= ctl_load_mode;
            pal_idx  <= '0;
            col      <= '0;
            row      <= '0;
            state    <= (ctl_load_mode == LM_BOTH || ctl_load_mode == LM_PAL)
                        ? SQ_PAL : SQ_FRAME;
          end
        end
        SQ_PAL: begin
          if (pal_hs) begin
            pal_idx <= pal_idx + 1'b1;
            if (pal_idx == '0) begin
              pal_last  <= pal_last_eff;
              pal_depth <= first_code;
            end
            if (pal_end) begin
              pal_idx <= '0;
              state   <= (run_mode == LM_PAL) ? SQ_HOLD : SQ_FRAME;
            end
          end
        end
        SQ_HOLD: begin
          if (!ctl_enable) state <= SQ_IDLE;
        end
        SQ_FRAME: begin
          if (frame_hs) begin
            if (col == COL_W'(LINE_WORDS - 1)) begin
              col <= '0;
              row <= (row == ROW_W'(FRAME_LINES - 1)) ? '0 : row + 1'b1;
            end else begin
              col <= col + 1'b1;
            end
            if (frame_end && !ctl_enable) state <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  // ---------------- palette storage ----------------
  pff_palette_ram #(.ENTRIES(PAL_BIG), .WIDTH(COLOR_W)) u_pal (
    .clk  (clk),
    .we   (pal_hs),
    .waddr(pal_idx),
    .wdata(s_data[COLOR_W-1:0]),
    .raddr(pal_rd_idx),
    .rdata(pal_rd_color)
  );

  // ---------------- pixel path ----------------
  assign fifo_pop = pix_req && pix_active && !fifo_empty;
  assign uf_evt   = pix_req && pix_active && fifo_empty;

  pff_pixel_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_fifo (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(start),
    .push (frame_hs),
    .din  (s_data),
    .pop  (fifo_pop),
    .dout (fifo_dout),
    .empty(fifo_empty),
    .full (fifo_full)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pix_data <= '0;
    else if (fifo_pop) pix_data <= fifo_dout;
    else               pix_data <= '0;
  end

  // ---------------- status flags ----------------
  logic [STAT_W-1:0] wr_ones;
  assign wr_ones = stat_wr ? stat_wdata : '0;

  always_comb begin
    set_vec         = '0;
    set_vec[B_DONE] = done_set;
    set_vec[B_PAL]  = pal_end;
    set_vec[B_UF]   = uf_evt;
    set_vec[B_SL]   = evt_sync_lost;
    set_vec[B_VS]   = evt_vsync;
    set_vec[B_LINE] = evt_line;
    set_vec[B_ACB]  = evt_acb;

    clr_vec         = '0;
    clr_vec[B_DONE] = start;
    clr_vec[B_PAL]  = (ctl_load_mode == LM_PAL) ? wr_ones[B_PAL] : en_fall;
    clr_vec[B_UF]   = en_fall;
    clr_vec[B_SL]   = en_fall;
    clr_vec[B_VS]   = wr_ones[B_VS];
    clr_vec[B_LINE] = wr_ones[B_LINE];
    clr_vec[B_ACB]  = wr_ones[B_ACB];
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_ones[B_DONE], wr_ones[B_UF], wr_ones[B_SL]};

  pff_status_regs #(.W(STAT_W)) u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(set_vec),
    .clr_vec(clr_vec),
    .flags  (status)
  );

  assign irq = |(status & irq_en);

  // ---------------- assertions ----------------
  assert_done_write_proof_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[B_DONE] && !start) |=> status[B_DONE]);
  assert_pal_only_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_end && run_mode == LM_PAL) |=> (!s_ready && status[B_PAL]));
  assert_underflow_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_req && pix_active && fifo_empty) |=> (pix_data == '0 && status[B_UF]));
  assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fall && !uf_evt && !evt_sync_lost) |=> (!status[B_UF] && !status[B_SL]));
  assert_done_goes_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> !s_ready);
endmodule

// File: tb/tb_pal_frame_fetch.sv
module tb_pal_frame_fetch;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_enable = 1'b0;
  logic [1:0] ctl_load_mode = 2'd0;
  logic [6:0] irq_en = '0;
  logic stat_wr = 1'b0;
  logic [6:0] stat_wdata = '0;
  logic evt_vsync = 1'b0, evt_line = 1'b0, evt_acb = 1'b0, evt_sync_lost = 1'b0;
  logic s_valid = 1'b0;
  logic [15:0] s_data = '0;
  logic s_ready;
  logic pix_req = 1'b0, pix_active = 1'b0;
  logic [15:0] pix_data;
  logic [7:0] pal_rd_idx = '0;
  logic [11:0] pal_rd_color;
  logic [3:0] pal_depth;
  logic [6:0] status;
  logic irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_frame_fetch dut (
    .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_load_mode(ctl_load_mode),
    .irq_en(irq_en), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .evt_vsync(evt_vsync), .evt_line(evt_line), .evt_acb(evt_acb),
    .evt_sync_lost(evt_sync_lost), .s_valid(s_valid), .s_data(s_data),
    .s_ready(s_ready), .pix_req(pix_req), .pix_active(pix_active),
    .pix_data(pix_data), .pal_rd_idx(pal_rd_idx), .pal_rd_color(pal_rd_color),
    .pal_depth(pal_depth), .status(status), .irq(irq)
  );

  function automatic logic [11:0] fcol(input int i);
    return 12'((i * 37 + 5) & 12'hfff);
  endfunction
  function automatic logic [11:0] gcol(input int i);
    return 12'((i * 91 + 12'h123) & 12'hfff);
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] d);
    s_data  = d;
    s_valid = 1'b1;
    while (s_ready !== 1'b1) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic pop_chk(input string r, input logic [15:0] exp);
    pix_req = 1'b1;
    pix_active = 1'b1;
    @(negedge clk);
    pix_req = 1'b0;
    pix_active = 1'b0;
    chk(r, 32'(pix_data), 32'(exp));
  endtask

  task automatic wr_status(input logic [6:0] v);
    stat_wr = 1'b1;
    stat_wdata = v;
    @(negedge clk);
    stat_wr = 1'b0;
    stat_wdata = '0;
  endtask

  task automatic readback(input string r, input int first, input int last, input bit use_g);
    for (int i = first; i <= last; i++) begin
      pal_rd_idx = 8'(i);
      @(negedge clk);
      chk(r, 32'(pal_rd_color), 32'(use_g ? gcol(i) : fcol(i)));
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all-R actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13 status", 32'(status), 0);
    chk("R13 irq", 32'(irq), 0);
    chk("R13 s_ready", 32'(s_ready), 0);
    chk("R13 pix_data", 32'(pix_data), 0);
    chk("R13 pal_depth", 32'(pal_depth), 0);

    // ---- palette only, 8 bpp indexed ----
    ctl_load_mode = 2'd1;
    ctl_enable = 1'b1;
    @(negedge clk);
    chk("R1 palette fetch starts", 32'(s_ready), 1);
    for (int i = 0; i < 256; i++) begin
      send({(i == 0) ? 4'h3 : 4'h0, fcol(i)});
      if (i == 254) chk("R2 long palette still open", 32'(s_ready), 1);
      if (i == 15)  chk("R2 no stop at 16 entries", 32'(status[1]), 0);
    end
    chk("R4 loaded flag same edge", 32'(status[1]), 1);
    chk("R4 ready drops", 32'(s_ready), 0);
    chk("R2 depth code", 32'(pal_depth), 32'h3);
    readback("R3 palette 256", 0, 255, 1'b0);
    chk("R12 masked irq", 32'(irq), 0);
    irq_en = 7'b0000010;
    #1 chk("R12 enabled irq", 32'(irq), 1);
    wr_status(7'h02);
    chk("R8 w1c in palette mode", 32'(status[1]), 0);
    chk("R12 irq follows clear", 32'(irq), 0);
    ctl_enable = 1'b0;
    @(negedge clk);
    chk("R5 hold ends with done", 32'(status[0]), 1);
    chk("R5 idle not ready", 32'(s_ready), 0);
    wr_status(7'h7F);
    chk("R6 done ignores write", 32'(status[0]), 1);

    // ---- palette only, direct colour ----
    ctl_enable = 1'b1;
    @(negedge clk);
    chk("R6 restart clears done", 32'(status[0]), 0);
    for (int i = 0; i < 16; i++) send({(i == 0) ? 4'h4 : 4'h3, gcol(i)});
    chk("R4 short loaded", 32'(status[1]), 1);
    chk("R4 short ready drops", 32'(s_ready), 0);
    chk("R2 depth code 4", 32'(pal_depth), 32'h4);
    readback("R2 short palette entries", 0, 15, 1'b1);
    readback("R2 entry past end kept", 16, 17, 1'b0);
    ctl_enable = 1'b0;
    @(negedge clk);
    chk("R8 disable keeps flag in palette mode", 32'(status[1]), 1);
    wr_status(7'h02);

    // ---- palette then frame ----
    ctl_load_mode = 2'd0;
    ctl_enable = 1'b1;
    @(negedge clk);
    chk("R1 mode0 starts with palette", 32'(s_ready), 1);
    for (int i = 0; i < 16; i++) send({(i == 0) ? 4'h4 : 4'h0, gcol(i)});
    chk("R1 mode0 loaded", 32'(status[1]), 1);
    chk("R1 mode0 continues to frame", 32'(s_ready), 1);
    wr_status(7'h02);
    chk("R8 w1c ignored in mode0", 32'(status[1]), 1);
    for (int k = 0; k < 4; k++) send(16'hA000 + 16'(k));
    chk("R11 full fifo back-pressure", 32'(s_ready), 0);
    for (int k = 0; k < 4; k++) pop_chk("R11 fifo order", 16'hA000 + 16'(k));
    ctl_enable = 1'b0;
    @(negedge clk);
    chk("R8 disable clears flag in mode0", 32'(status[1]), 0);
    for (int k = 4; k < 12; k++) begin
      send(16'hA000 + 16'(k));
      if (k == 10) chk("R5 no done before last word", 32'(status[0]), 0);
      if (k == 11) begin
        chk("R5 done at last word", 32'(status[0]), 1);
        chk("R5 idle after frame", 32'(s_ready), 0);
      end
      pop_chk("R11 drain order", 16'hA000 + 16'(k));
    end

    // ---- frame only with underflow ----
    pix_req = 1'b1;
    @(negedge clk);
    pix_req = 1'b0;
    chk("R10 inactive request no flag", 32'(status[2]), 0);
    chk("R10 inactive request zero", 32'(pix_data), 0);
    ctl_load_mode = 2'd2;
    ctl_enable = 1'b1;
    @(negedge clk);
    chk("R1 frame only skips palette", 32'(s_ready), 1);
    pop_chk("R10 underflow outputs zero", 16'h0000);
    chk("R10 underflow flag", 32'(status[2]), 1);
    irq_en = 7'b0000100;
    #1 chk("R12 underflow irq", 32'(irq), 1);
    irq_en = 7'b0000000;
    #1 chk("R12 masked underflow", 32'(irq), 0);
    wr_status(7'h04);
    chk("R7 underflow ignores write", 32'(status[2]), 1);
    for (int k = 0; k < 14; k++) begin
      send(16'hB000 + 16'(k));
      if (k == 11) begin
        chk("R5 frames repeat while enabled", 32'(s_ready), 1);
        chk("R5 no done while enabled", 32'(status[0]), 0);
      end
      pop_chk("R11 frame-only order", 16'hB000 + 16'(k));
    end
    ctl_enable = 1'b0;
    @(negedge clk);
    chk("R7 disable clears underflow", 32'(status[2]), 0);
    for (int k = 14; k < 24; k++) begin
      send(16'hB000 + 16'(k));
      if (k == 23) chk("R5 done after second frame", 32'(status[0]), 1);
      pop_chk("R11 second frame order", 16'hB000 + 16'(k));
    end

    // ---- event flags ----
    evt_vsync = 1'b1; evt_line = 1'b1; evt_acb = 1'b1; evt_sync_lost = 1'b1;
    @(negedge clk);
    evt_vsync = 1'b0; evt_line = 1'b0; evt_acb = 1'b0; evt_sync_lost = 1'b0;
    chk("R9 event flags set", 32'(status[6:3]), 32'hF);
    evt_line = 1'b1;
    wr_status(7'h78);
    evt_line = 1'b0;
    chk("R9 w1c vsync", 32'(status[4]), 0);
    chk("R9 set beats clear", 32'(status[5]), 1);
    chk("R9 w1c acb", 32'(status[6]), 0);
    chk("R7 sync lost ignores write", 32'(status[3]), 1);
    wr_status(7'h20);
    chk("R9 w1c line", 32'(status[5]), 0);

    // ---- mode 3 behaves as frame only ----
    ctl_load_mode = 2'd3;
    ctl_enable = 1'b1;
    @(negedge clk);
    chk("R1 mode3 goes to frame", 32'(s_ready), 1);
    send(16'h3ABC);
    pop_chk("R1 mode3 word is a pixel", 16'h3ABC);
    readback("R1 mode3 palette untouched", 0, 0, 1'b1);
    ctl_enable = 1'b0;
    @(negedge clk);
    chk("R7 disable clears sync lost", 32'(status[3]), 0);
    for (int k = 1; k < 12; k++) begin
      send(16'hC000 + 16'(k));
      pop_chk("R11 mode3 order", 16'hC000 + 16'(k));
    end
    chk("R5 mode3 done", 32'(status[0]), 1);

    summary();
    $finish;
  end
endmodule